// File: doc/BRIEF.md
# PIO Timing to Clock Converter

This block turns the nanosecond timing of a programmed-I/O transfer mode into the bus-clock counts that a disk interface timing unit needs. The three times it takes for each of two drives are the address setup time, the active (strobe) time and the full cycle time. It also takes the bus clock in MHz. For each drive it produces three counts: address setup, data pulse and recovery. Each count is rounded up to whole clocks and clamped to what the timing hardware can hold. The block then packs the counts into one cycle byte per drive and one shared configuration byte. The shared byte carries the larger of the two address setup counts, because both drives use the same setup field.

Software or a boot sequencer places the mode times on the inputs and pulses `start_i`. The block copies every input in that cycle. It converts the six times one after another through a shift-and-subtract divider by 1000. When all three bytes are valid, it raises `done_o` for one cycle. A drive marked absent skips the divider and gets the smallest legal counts. The state machine has four states: IDLE (waits for start), ISSUE (picks the next time and launches a divide, or fills minima for an absent drive), WAIT (waits for the divider result, clamps it and stores it) and PACK (loads the output bytes and raises done). Its transitions are:
- IDLE to ISSUE on start.
- ISSUE to WAIT when the drive is present.
- ISSUE to ISSUE when drive 0 is absent.
- ISSUE to PACK when drive 1 is absent.
- WAIT to ISSUE after a result that is not the last one.
- WAIT to PACK after the recovery count of drive 1.
- PACK to IDLE, unconditionally.

Top module: `pio_clk_conv`

## Requirements
- R1: Each count before clamping equals ceil(time_ns × MHz / 1000), that is (time × MHz + 999) / 1000 in integer division. For example, 80 ns at 40 MHz gives 4 clocks.
- R2: The recovery time in ns is cycle − setup − active. If that difference is negative, it is taken as 0 before conversion.
- R3: Address counts are clamped to 1..4, data counts to 1..16 and recovery counts to 2..17.
- R4: A drive whose present input is low gets address 1, data 1 and recovery 2, whatever its time inputs are.
- R5: The address field of the shared byte uses the larger of the two drives' address counts.
- R6: Each drive's cycle byte holds data−1 in bits 7:4 and recovery−2 in bits 3:0. Drive 0's byte is on `cyc0_o` and drive 1's byte is on `cyc1_o`.
- R7: The shared byte has these fields:
  - bit 6: the prefetch input
  - bits 5:4: address−1
  - bits 3:1: the ready-wait count minus 2 (the ready-wait count is fixed at 2, so this field is 0)
  - bits 7 and 0: always 0
- R8: A start seen while idle makes `busy_o` high in the next cycle and copies all inputs. Later changes to the inputs have no effect on that conversion. A start seen while busy is ignored.
- R9: `done_o` is high for exactly one cycle, in the same cycle that the new bytes appear. The output bytes hold their values until the next done.
- R10: After reset, all output bytes are 0 and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when idle |
| bus_mhz_i | input | MHZ_W | Bus clock frequency in MHz |
| prefetch_i | input | 1 | Read prefetch enable, placed in the shared byte |
| d0_present_i | input | 1 | Drive 0 is present |
| d0_setup_ns_i | input | TIME_W | Drive 0 address setup time, ns |
| d0_active_ns_i | input | TIME_W | Drive 0 active pulse time, ns |
| d0_cycle_ns_i | input | TIME_W | Drive 0 total cycle time, ns |
| d1_present_i | input | 1 | Drive 1 is present |
| d1_setup_ns_i | input | TIME_W | Drive 1 address setup time, ns |
| d1_active_ns_i | input | TIME_W | Drive 1 active pulse time, ns |
| d1_cycle_ns_i | input | TIME_W | Drive 1 total cycle time, ns |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse: the bytes below are new |
| cyc0_o | output | 8 | Drive 0 cycle byte |
| cyc1_o | output | 8 | Drive 1 cycle byte |
| misc_o | output | 8 | Shared configuration byte |

## Verification
If the sequencer steps through the conversions wrongly, for example by skipping a kind or storing a result into the wrong drive, one nibble of the bytes at `done_o` comes out wrong. The bench sees this on the very first conversion that uses unequal drive times. A divider that stops one step early or late roughly halves or doubles a count, so the effect shows at once in any vector whose count is not clamped. A fault in the handshake or in holding the state appears at the ports within one conversion, about 130 cycles. It shows as a missing or doubled done pulse, or as bytes that change between pulses or follow inputs changed after start.

// File: rtl/pio_conv_pkg.sv
package pio_conv_pkg;

    // clock-count limits accepted by the timing registers
    localparam int ADDR_MIN = 1;
    localparam int ADDR_MAX = 4;
    localparam int DATA_MIN = 1;
    localparam int DATA_MAX = 16;
    localparam int REC_MIN  = 2;
    localparam int REC_MAX  = 17;
    localparam int CNT_W    = 5;
    localparam int NS_DIV   = 1000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_PACK
    } conv_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_DATA,
        K_REC
    } time_kind_e;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [31:0] v,
                                                    input int lo, input int hi);
        if (v < 32'(lo))      return CNT_W'(lo);
        else if (v > 32'(hi)) return CNT_W'(hi);
        else                  return v[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pio_div1000.sv
module pio_div1000 #(
    parameter int NUM_W = 19,
    parameter int DIV   = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] numer,
    output logic [NUM_W-1:0] quot,
    output logic             ready
);
    localparam int REM_W = $clog2(DIV) + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] steps_q;
    logic [REM_W-1:0] trial;

    // shift the next dividend bit into the partial remainder
    assign trial = {rem_q[REM_W-2:0], quot[NUM_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quot    <= '0;
            steps_q <= '0;
            ready   <= 1'b0;
        end else if (go) begin
            rem_q   <= '0;
            quot    <= numer;
            steps_q <= CNT_W'(NUM_W);
            ready   <= 1'b0;
        end else if (steps_q != '0) begin
            if (trial >= REM_W'(DIV)) begin
                rem_q <= trial - REM_W'(DIV);
                quot  <= {quot[NUM_W-2:0], 1'b1};
            end else begin
                rem_q <= trial;
                quot  <= {quot[NUM_W-2:0], 1'b0};
            end
            steps_q <= steps_q - 1'b1;
            ready   <= (steps_q == CNT_W'(1));
        end else begin
            ready <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_pack.sv
module pio_pack
    import pio_conv_pkg::*;
#(
    parameter int DRDY_CLKS = 2
) (
    input  logic [1:0][CNT_W-1:0] addr_c,
    input  logic [1:0][CNT_W-1:0] data_c,
    input  logic [1:0][CNT_W-1:0] rec_c,
    input  logic                  prefetch,
    output logic [1:0][7:0]       cyc_b,
    output logic [7:0]            misc_b
);
    localparam logic [2:0] DRDY_FIELD = 3'(DRDY_CLKS - 2);

    logic [CNT_W-1:0] addr_max;
    logic [CNT_W-1:0] addr_m1;

    for (genvar d = 0; d < 2; d++) begin : g_drv
        logic [CNT_W-1:0] dm1, rm2;
        assign dm1      = data_c[d] - CNT_W'(1);
        assign rm2      = rec_c[d] - CNT_W'(2);
        assign cyc_b[d] = {dm1[3:0], rm2[3:0]};
    end

    assign addr_max = (addr_c[0] > addr_c[1]) ? addr_c[0] : addr_c[1];
    assign addr_m1  = addr_max - CNT_W'(1);
    assign misc_b   = {1'b0, prefetch, addr_m1[1:0], DRDY_FIELD, 1'b0};
endmodule

// File: rtl/pio_clk_conv.sv
module pio_clk_conv
    import pio_conv_pkg::*;
#(
    parameter int TIME_W    = 10,
    parameter int MHZ_W     = 8,
    parameter int DRDY_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MHZ_W-1:0]  bus_mhz_i,
    input  logic              prefetch_i,
    input  logic              d0_present_i,
    input  logic [TIME_W-1:0] d0_setup_ns_i,
    input  logic [TIME_W-1:0] d0_active_ns_i,
    input  logic [TIME_W-1:0] d0_cycle_ns_i,
    input  logic              d1_present_i,
    input  logic [TIME_W-1:0] d1_setup_ns_i,
    input  logic [TIME_W-1:0] d1_active_ns_i,
    input  logic [TIME_W-1:0] d1_cycle_ns_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [7:0]        cyc0_o,
    output logic [7:0]        cyc1_o,
    output logic [7:0]        misc_o
);
    localparam int NUM_W = TIME_W + MHZ_W + 1;

    conv_state_e state_q, state_d;
    time_kind_e  kind_q;
    logic        drv_q;

    logic [MHZ_W-1:0]  mhz_q;
    logic              pf_q;
    logic [1:0]        present_q;
    logic [TIME_W-1:0] setup_q  [2];
    logic [TIME_W-1:0] active_q [2];
    logic [TIME_W-1:0] cycle_q  [2];

    logic [1:0][CNT_W-1:0] addr_c, data_c, rec_c;

    logic [TIME_W:0]   sum_ns;
    logic [TIME_W-1:0] rec_ns;
    logic [TIME_W-1:0] t_sel;
    logic [NUM_W-1:0]  numer, quot;
    logic              div_go, div_ready;
    logic [CNT_W-1:0]  cnt_clamped;
    logic [1:0][7:0]   pk_cyc;
    logic [7:0]        pk_misc;

    // recovery = cycle - setup - active, floored at zero (R2)
    assign sum_ns = (TIME_W+1)'(setup_q[drv_q]) + (TIME_W+1)'(active_q[drv_q]);
    assign rec_ns = ({1'b0, cycle_q[drv_q]} >= sum_ns)
                  ? TIME_W'({1'b0, cycle_q[drv_q]} - sum_ns) : '0;

    always_comb begin
        unique case (kind_q)
            K_ADDR:  t_sel = setup_q[drv_q];
            K_DATA:  t_sel = active_q[drv_q];
            K_REC:   t_sel = rec_ns;
            default: t_sel = '0;
        endcase
    end

    assign numer  = NUM_W'(t_sel) * NUM_W'(mhz_q) + NUM_W'(NS_DIV - 1);
    assign div_go = (state_q == ST_ISSUE) && present_q[drv_q];

    pio_div1000 #(.NUM_W(NUM_W), .DIV(NS_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (numer),
        .quot  (quot),
        .ready (div_ready)
    );

    always_comb begin
        unique case (kind_q)
            K_ADDR:  cnt_clamped = clamp_cnt(32'(quot), ADDR_MIN, ADDR_MAX);
            K_DATA:  cnt_clamped = clamp_cnt(32'(quot), DATA_MIN, DATA_MAX);
            K_REC:   cnt_clamped = clamp_cnt(32'(quot), REC_MIN, REC_MAX);
            default: cnt_clamped = '0;
        endcase
    end

    pio_pack #(.DRDY_CLKS(DRDY_CLKS)) u_pack (
        .addr_c   (addr_c),
        .data_c   (data_c),
        .rec_c    (rec_c),
        .prefetch (pf_q),
        .cyc_b    (pk_cyc),
        .misc_b   (pk_misc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (present_q[drv_q]) state_d = ST_WAIT;
                else if (drv_q)       state_d = ST_PACK;
                else                  state_d = ST_ISSUE;
            end
            ST_WAIT: begin
                if (div_ready)
                    state_d = (kind_q == K_REC && drv_q) ? ST_PACK : ST_ISSUE;
            end
            ST_PACK:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy_o = (state_q != ST_IDLE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= K_ADDR;
            drv_q     <= 1'b0;
            mhz_q     <= '0;
            pf_q      <= 1'b0;
            present_q <= '0;
            setup_q   <= '{default: '0};
            active_q  <= '{default: '0};
            cycle_q   <= '{default: '0};
            addr_c    <= '0;
            data_c    <= '0;
            rec_c     <= '0;
            done_o    <= 1'b0;
            cyc0_o    <= '0;
            cyc1_o    <= '0;
            misc_o    <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mhz_q       <= bus_mhz_i;
                        pf_q        <= prefetch_i;
                        present_q   <= {d1_present_i, d0_present_i};
                        setup_q[0]  <= d0_setup_ns_i;
                        active_q[0] <= d0_active_ns_i;
                        cycle_q[0]  <= d0_cycle_ns_i;
                        setup_q[1]  <= d1_setup_ns_i;
                        active_q[1] <= d1_active_ns_i;
                        cycle_q[1]  <= d1_cycle_ns_i;
                        drv_q       <= 1'b0;
                        kind_q      <= K_ADDR;
                    end
                end
                ST_ISSUE: begin
                    if (!present_q[drv_q]) begin
                        addr_c[drv_q] <= CNT_W'(ADDR_MIN);
                        data_c[drv_q] <= CNT_W'(DATA_MIN);
                        rec_c[drv_q]  <= CNT_W'(REC_MIN);
                        drv_q         <= 1'b1;
                        kind_q        <= K_ADDR;
                    end
                end
                ST_WAIT: begin
                    if (div_ready) begin
                        unique case (kind_q)
                            K_ADDR: begin
                                addr_c[drv_q] <= cnt_clamped;
                                kind_q        <= K_DATA;
                            end
                            K_DATA: begin
                                data_c[drv_q] <= cnt_clamped;
                                kind_q        <= K_REC;
                            end
                            default: begin
                                rec_c[drv_q] <= cnt_clamped;
                                kind_q       <= K_ADDR;
                                drv_q        <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_PACK: begin
                    cyc0_o <= pk_cyc[0];
                    cyc1_o <= pk_cyc[1];
                    misc_o <= pk_misc;
                    done_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pio_clk_conv_chk.sv
module pio_clk_conv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] cyc0_o,
    input logic [7:0] cyc1_o,
    input logic [7:0] misc_o
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_hold_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cyc0_o) && $stable(cyc1_o) && $stable(misc_o)));

    p_misc_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (misc_o[7] == 1'b0 && misc_o[0] == 1'b0));
endmodule

bind pio_clk_conv pio_clk_conv_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cyc0_o  (cyc0_o),
    .cyc1_o  (cyc1_o),
    .misc_o  (misc_o)
);

// File: tb/tb_pio_clk_conv.sv
module tb_pio_clk_conv;
    localparam int TIME_W = 10;
    localparam int MHZ_W  = 8;
    localparam int NV     = 7;
    localparam int RUN_LIMIT = 2000;

    // mhz, p0, s0, a0, c0, p1, s1, a1, c1, prefetch
    localparam int VEC [NV][10] = '{
        '{ 40, 1,   70, 165,  600, 1, 30,  80, 180, 1},
        '{ 33, 1,   70, 290,  600, 1, 50, 125, 383, 0},
        '{ 25, 1,   30,  80,  120, 0,  0,   0,   0, 1},
        '{ 66, 1,   25,  70,  120, 1, 25,  70, 120, 0},
        '{100, 1,  200, 300, 1000, 1, 10,  20,  10, 1},
        '{250, 1, 1000, 900, 1023, 1,  0,   0,   0, 0},
        '{ 20, 0,  500, 500,  900, 0,  9,   9,   9, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [MHZ_W-1:0] bus_mhz_i = '0;
    logic prefetch_i = 1'b0;
    logic d0_present_i = 1'b0, d1_present_i = 1'b0;
    logic [TIME_W-1:0] d0_setup_ns_i = '0, d0_active_ns_i = '0, d0_cycle_ns_i = '0;
    logic [TIME_W-1:0] d1_setup_ns_i = '0, d1_active_ns_i = '0, d1_cycle_ns_i = '0;
    logic busy_o, done_o;
    logic [7:0] cyc0_o, cyc1_o, misc_o;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (done_o) done_cnt <= done_cnt + 1;

    pio_clk_conv #(.TIME_W(TIME_W), .MHZ_W(MHZ_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_mhz_i(bus_mhz_i),
        .prefetch_i(prefetch_i),
        .d0_present_i(d0_present_i), .d0_setup_ns_i(d0_setup_ns_i),
        .d0_active_ns_i(d0_active_ns_i), .d0_cycle_ns_i(d0_cycle_ns_i),
        .d1_present_i(d1_present_i), .d1_setup_ns_i(d1_setup_ns_i),
        .d1_active_ns_i(d1_active_ns_i), .d1_cycle_ns_i(d1_cycle_ns_i),
        .busy_o(busy_o), .done_o(done_o),
        .cyc0_o(cyc0_o), .cyc1_o(cyc1_o), .misc_o(misc_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int ref_cnt(int t, int mhz, int lo, int hi);
        int v = (t * mhz + 999) / 1000;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return v;
    endfunction

    // expected bytes: [0]=cyc0 [1]=cyc1 [2]=misc
    task automatic ref_bytes(input int v [10], output int e [3]);
        int a [2], d [2], r [2];
        for (int k = 0; k < 2; k++) begin
            int p = v[1 + 4*k], s = v[2 + 4*k], ac = v[3 + 4*k], c = v[4 + 4*k];
            if (p == 0) begin
                a[k] = 1; d[k] = 1; r[k] = 2;
            end else begin
                int rn = c - s - ac;
                if (rn < 0) rn = 0;
                a[k] = ref_cnt(s, v[0], 1, 4);
                d[k] = ref_cnt(ac, v[0], 1, 16);
                r[k] = ref_cnt(rn, v[0], 2, 17);
            end
            e[k] = ((d[k] - 1) << 4) | (r[k] - 2);
        end
        e[2] = (v[9] << 6) | (((a[0] > a[1] ? a[0] : a[1]) - 1) << 4);
    endtask

    task automatic apply(input int v [10]);
        bus_mhz_i      = MHZ_W'(v[0]);
        d0_present_i   = v[1][0];
        d0_setup_ns_i  = TIME_W'(v[2]);
        d0_active_ns_i = TIME_W'(v[3]);
        d0_cycle_ns_i  = TIME_W'(v[4]);
        d1_present_i   = v[5][0];
        d1_setup_ns_i  = TIME_W'(v[6]);
        d1_active_ns_i = TIME_W'(v[7]);
        d1_cycle_ns_i  = TIME_W'(v[8]);
        prefetch_i     = v[9][0];
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < RUN_LIMIT) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) begin
            total++; bad++;
            $display("FAIL R9 done never rose actual=0 expected=1");
        end
    endtask

    task automatic run(input int v [10]);
        @(negedge clk);
        apply(v);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy after start", int'(busy_o), 1);
        wait_done();
    endtask

    task automatic check_bytes(input string tag, input int e [3]);
        check({tag, " R6 cyc0"}, int'(cyc0_o), e[0]);
        check({tag, " R6 cyc1"}, int'(cyc1_o), e[1]);
        check({tag, " R5/R7 misc"}, int'(misc_o), e[2]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e [3];
        int dc;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 busy", int'(busy_o), 0);
        check("R10 done", int'(done_o), 0);
        check("R10 cyc0", int'(cyc0_o), 0);
        check("R10 cyc1", int'(cyc1_o), 0);
        check("R10 misc", int'(misc_o), 0);
        rst_n = 1'b1;

        // vector table, R1 R2 R3 R4 covered by the reference model
        for (int i = 0; i < NV; i++) begin
            ref_bytes(VEC[i], e);
            run(VEC[i]);
            check_bytes($sformatf("vec%0d R1", i), e);
            @(negedge clk);
            check("R9 done one cycle", int'(done_o), 0);
        end

        // R1: 40 MHz, 80 ns -> 4 clocks (drive 1 data nibble 3); hand values
        run(VEC[0]);
        check("R1 cyc0 hand", int'(cyc0_o), 'h6D);
        check("R1 cyc1 hand", int'(cyc1_o), 'h31);
        check("R5 misc hand", int'(misc_o), 'h60);

        // R2/R3: negative recovery floors to min, counts saturate high
        run(VEC[5]);
        check("R2 R3 cyc0 clamp", int'(cyc0_o), 'hF0);
        check("R3 cyc1 low clamp", int'(cyc1_o), 'h00);
        check("R3 misc addr max", int'(misc_o), 'h30);
        run(VEC[4]);
        check("R3 cyc0 upper", int'(cyc0_o), 'hFF);

        // R4: both absent -> minima regardless of time inputs
        run(VEC[6]);
        check("R4 cyc0 absent", int'(cyc0_o), 'h00);
        check("R4 cyc1 absent", int'(cyc1_o), 'h00);
        check("R4 misc absent", int'(misc_o), 'h40);

        // R8: inputs changed and start pulsed mid-run are ignored
        ref_bytes(VEC[1], e);
        @(negedge clk);
        dc = done_cnt;
        apply(VEC[1]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        apply(VEC[5]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check_bytes("R8 ignore", e);
        repeat (200) @(negedge clk);
        check("R8 single done", done_cnt - dc, 1);
        check("R9 hold cyc0", int'(cyc0_o), e[0]);
        check("R8 idle after", int'(busy_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule